// File: doc/BRIEF.md
# Reciprocal Square Root Seed Unit

This block turns one single-precision operand into a rough starting value for 1/sqrt(x). An iterative refinement stage downstream is expected to improve that value. The unit does no arithmetic on the fraction. For a positive normal operand it computes the result exponent directly from the input exponent. It takes an 8-bit significand from a fixed lookup table, indexed by the parity of the biased exponent minus one and by the six leading fraction bits. Operands outside the normal positive range get fixed result patterns.

An operand is accepted in any cycle where `in_valid` is high. Its result, its invalid flag and its summary flag appear on the registered outputs one cycle later, marked by `out_valid`. When no operand is offered, the outputs keep their last values.

Top module: `rsq_seed`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_res`, `out_invalid` and `out_summary` change only in the cycle after an accepted operand, and hold their values otherwise.
- R2: While synchronous reset `rst` is high, `out_valid`, `out_res`, `out_invalid` and `out_summary` are all zero at the next clock edge.
- R3: An operand whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is non-zero yields 0x7FC00000, whatever its sign. When fraction bit 22 is 1 (a quiet NaN), no flag is raised.
- R4: A NaN operand with fraction bit 22 equal to 0 (a signaling NaN) yields 0x7FC00000 and raises both `out_invalid` and `out_summary`.
- R5: An operand with exponent field zero (a zero or a denormal) yields infinity: the input sign bit, then exponent 0xFF, then a zero fraction. No flag is raised.
- R6: A negative operand that is not a NaN and has a non-zero exponent field (a negative normal or negative infinity) yields 0x7FC00004 and raises both flags.
- R7: Positive infinity (0x7F800000) yields 0x00000000 with no flag.
- R8: For a positive normal operand with biased exponent E, let e1 = E - 1. The result sign is the input sign and the result exponent field is 0xBD - floor(e1/2). Result bits 14:0 are zero and no flag is raised.
- R9: For a positive normal operand, result bits 22:15 equal table entry {e1[0], fraction bits 22:17}, a 7-bit index. The table has 128 non-increasing 8-bit entries. Each odd index holds the entry before it minus one. The even-index entries in index order are 253,245,239,231,225,217,211,205,201,195,189,185,179,175,169,165,161,157,153,149,145,141,137,133,131,127,123,121,117,115,111,109,103,99,93,89,83,79,75,71,67,63,59,55,53,49,45,43,39,37,33,31,27,25,23,19,17,15,13,11,9,7,5,3. The first entry is therefore 253 and the last is 2.
- R10: `out_summary` equals `out_invalid` for every result and is low for every operand class other than those in R4 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 32 | Seed result |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_summary | output | 1 | Summary status flag for this result |

## Verification
The assertions assume that `in_op` is known in every cycle where `in_valid` is high. They also assume that reset has been applied before the first operand, so that the one-cycle relations have a defined prior cycle. The bench drives inputs only on falling edges and holds `in_op` fixed across each accepted cycle. It takes `in_valid` low between some operands, so the hold behaviour is exercised alongside back-to-back streams. Every table index is reached through operands with exponents 127 and 128, together with the extreme exponents 1 and 254 and each special class.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int FP_W      = 32;
    localparam int EXP_W     = 8;
    localparam int FRAC_W    = 23;
    localparam int SEED_W    = 8;
    localparam int SEED_MANT = 6;

    localparam logic [FP_W-1:0]  RES_QNAN        = 32'h7FC0_0000;
    localparam logic [FP_W-1:0]  RES_NEG_INVALID = 32'h7FC0_0004;
    localparam logic [EXP_W-1:0] EXP_ALL1        = '1;
    localparam logic [EXP_W-1:0] EXP_OFFSET      = 8'hBD;

    typedef enum logic [2:0] {
        CLS_QNAN,
        CLS_SNAN,
        CLS_ZERO,
        CLS_NEG,
        CLS_PINF,
        CLS_NORM
    } op_class_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        logic [FP_W-1:0] value;
        logic            invalid;
    } seed_res_t;

    function automatic logic [SEED_MANT:0] seed_index(fp_t f);
        logic [EXP_W-1:0] e1;
        e1 = f.expo - 1'b1;
        return {e1[0], f.frac[FRAC_W-1 -: SEED_MANT]};
    endfunction

    function automatic logic [EXP_W-1:0] seed_exp(fp_t f);
        logic [EXP_W-1:0] e1;
        e1 = f.expo - 1'b1;
        return EXP_OFFSET - (e1 >> 1);
    endfunction

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
    import rsq_pkg::*;
(
    input  fp_t       op,
    output op_class_e cls
);

    logic exp_max;
    logic exp_zero;
    logic frac_nz;

    assign exp_max  = (op.expo == EXP_ALL1);
    assign exp_zero = (op.expo == '0);
    assign frac_nz  = |op.frac;

    // Priority: NaN first, then zero/denormal, then sign, then infinity
    always_comb begin
        if (exp_max && frac_nz) begin
            cls = op.frac[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
        end else if (exp_zero) begin
            cls = CLS_ZERO;
        end else if (op.sign) begin
            cls = CLS_NEG;
        end else if (exp_max) begin
            cls = CLS_PINF;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/rsq_seed_rom.sv
module rsq_seed_rom #(
    parameter int MANT_BITS = 6,
    parameter int SEED_BITS = 8
) (
    input  logic [MANT_BITS:0]   idx,
    output logic [SEED_BITS-1:0] seed
);

    localparam int PAIRS  = 2 ** MANT_BITS;
    localparam int STEP_W = SEED_BITS - 1;

    // Upper bits shared by each even/odd entry pair; the LSB is 1 on even
    // indices and 0 on odd ones.
    localparam int PAIR_TAB [PAIRS] = '{
        126, 122, 119, 115, 112, 108, 105, 102, 100, 97,
        94,  92,  89,  87,  84,  82,  80,  78,  76,  74,
        72,  70,  68,  66,  65,  63,  61,  60,  58,  57,
        55,  54,  51,  49,  46,  44,  41,  39,  37,  35,
        33,  31,  29,  27,  26,  24,  22,  21,  19,  18,
        16,  15,  13,  12,  11,  9,   8,   7,   6,   5,
        4,   3,   2,   1
    };

    logic [STEP_W-1:0] pair_val;

    always_comb begin
        pair_val = STEP_W'(PAIR_TAB[idx[MANT_BITS:1]]);
        seed     = {pair_val, ~idx[0]};
    end

endmodule

// File: rtl/rsq_assemble.sv
module rsq_assemble
    import rsq_pkg::*;
(
    input  fp_t               op,
    input  op_class_e         cls,
    input  logic [SEED_W-1:0] seed,
    output seed_res_t         res
);

    localparam int PAD_W = FRAC_W - SEED_W;

    always_comb begin
        res.invalid = 1'b0;
        unique case (cls)
            CLS_QNAN: res.value = RES_QNAN;
            CLS_SNAN: begin
                res.value   = RES_QNAN;
                res.invalid = 1'b1;
            end
            CLS_ZERO: res.value = {op.sign, EXP_ALL1, {FRAC_W{1'b0}}};
            CLS_NEG: begin
                res.value   = RES_NEG_INVALID;
                res.invalid = 1'b1;
            end
            CLS_PINF: res.value = '0;
            default:  res.value = {op.sign, seed_exp(op), seed, {PAD_W{1'b0}}};
        endcase
    end

endmodule

// File: rtl/rsq_seed.sv
module rsq_seed
    import rsq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [FP_W-1:0] in_op,
    output logic            out_valid,
    output logic [FP_W-1:0] out_res,
    output logic            out_invalid,
    output logic            out_summary
);

    fp_t               op_f;
    op_class_e         cls;
    logic [SEED_W-1:0] seed;
    seed_res_t         nxt;

    assign op_f = fp_t'(in_op);

    rsq_classify u_classify (
        .op  (op_f),
        .cls (cls)
    );

    rsq_seed_rom #(
        .MANT_BITS (SEED_MANT),
        .SEED_BITS (SEED_W)
    ) u_rom (
        .idx  (seed_index(op_f)),
        .seed (seed)
    );

    rsq_assemble u_assemble (
        .op   (op_f),
        .cls  (cls),
        .seed (seed),
        .res  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_res     <= '0;
            out_invalid <= 1'b0;
            out_summary <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res     <= nxt.value;
                out_invalid <= nxt.invalid;
                out_summary <= nxt.invalid;
            end
        end
    end

    logic in_nan;
    logic in_pos_norm;
    assign in_nan      = (in_op[30:23] == 8'hFF) && (in_op[22:0] != '0);
    assign in_pos_norm = !in_op[31] && (in_op[30:23] != 8'h00) && (in_op[30:23] != 8'hFF);

    AST_LAT_ON: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                            // R1
    AST_LAT_OFF: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                          // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_res) && $stable(out_invalid));            // R1
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_nan |=> out_res == 32'h7FC0_0000);                   // R3
    AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_nan && !in_op[22] |=> out_invalid && out_summary);   // R4
    AST_INV_CANON: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_invalid |->
            (out_res == 32'h7FC0_0000) || (out_res == 32'h7FC0_0004));     // R6
    AST_NORM_LOW: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_pos_norm |=> (out_res[14:0] == '0) && !out_invalid); // R8

endmodule

// File: tb/rsq_seed_tb.sv
module rsq_seed_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_op = '0;
    logic        out_valid;
    logic [31:0] out_res;
    logic        out_invalid;
    logic        out_summary;

    always #5 clk = ~clk;

    rsq_seed u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .out_valid   (out_valid),
        .out_res     (out_res),
        .out_invalid (out_invalid),
        .out_summary (out_summary)
    );

    // Even-index entries of the seed table; odd index = previous minus one (R9)
    localparam bit [7:0] EVEN_SEED [64] = '{
        253, 245, 239, 231, 225, 217, 211, 205, 201, 195,
        189, 185, 179, 175, 169, 165, 161, 157, 153, 149,
        145, 141, 137, 133, 131, 127, 123, 121, 117, 115,
        111, 109, 103, 99,  93,  89,  83,  79,  75,  71,
        67,  63,  59,  55,  53,  49,  45,  43,  39,  37,
        33,  31,  27,  25,  23,  19,  17,  15,  13,  11,
        9,   7,   5,   3
    };

    typedef struct {
        logic [31:0] res;
        logic        inv;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails = 0;
    logic [31:0] last_res = '0;
    bit          have_last = 0;

    function automatic exp_t model(input logic [31:0] x);
        exp_t       e;
        logic [7:0] ex;
        logic [7:0] e1;
        logic [6:0] idx;
        logic [7:0] v;
        ex    = x[30:23];
        e.inv = 1'b0;
        if (ex == 8'hFF && x[22:0] != 0) begin
            e.res = 32'h7FC00000;
            e.inv = !x[22];
            e.tag = x[22] ? "R3" : "R4";
        end else if (ex == 0) begin
            e.res = {x[31], 8'hFF, 23'd0};
            e.tag = "R5";
        end else if (x[31]) begin
            e.res = 32'h7FC00004;
            e.inv = 1'b1;
            e.tag = "R6";
        end else if (ex == 8'hFF) begin
            e.res = 32'h0;
            e.tag = "R7";
        end else begin
            e1    = ex - 8'd1;
            idx   = {e1[0], x[22:17]};
            v     = EVEN_SEED[idx[6:1]] - {7'd0, idx[0]};
            e.res = {x[31], 8'hBD - (e1 >> 1), v, 15'd0};
            e.tag = "R8 R9";
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] x);
        in_valid = 1'b1;
        in_op    = x;
        sb.push_back(model(x));
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_op    = 32'hDEAD_BEEF;
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R1 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " result"}, out_res, e.res);
                    check({e.tag, " invalid"}, {31'd0, out_invalid}, {31'd0, e.inv});
                    check("R10 summary", {31'd0, out_summary}, {31'd0, e.inv});
                end
                last_res  = out_res;
                have_last = 1;
            end else if (have_last) begin
                check("R1 hold", out_res, last_res);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        in_valid = 1'b1;
        in_op    = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        check("R2 out_valid", {31'd0, out_valid}, 32'd0);
        check("R2 out_res", out_res, 32'd0);
        check("R2 flags", {30'd0, out_invalid, out_summary}, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R3 quiet NaNs
        send(32'h7FC00000); send(32'h7FC12345); send(32'hFFC00000);
        idle(2);
        // R4 signaling NaNs
        send(32'h7F800001); send(32'hFFA00000);
        // R5 zero / denormal
        send(32'h00000000); send(32'h80000000); send(32'h00000001); send(32'h807FFFFF);
        idle(1);
        // R6 negative normal / negative infinity
        send(32'hBF800000); send(32'hFF800000); send(32'h80800000);
        // R7 positive infinity
        send(32'h7F800000);
        idle(3);
        // R8 exponent extremes: E=1 -> 0xBD with seed 253, E=254 -> 0x3F with seed 2
        send(32'h00800000); send(32'h7F7FFFFF);
        // R9 full table sweep via E=127 (even e1) and E=128 (odd e1)
        for (int i = 0; i < 128; i++) begin
            logic [6:0]  ii;
            logic [16:0] low;
            ii  = 7'(i);
            low = 17'(i * 977);
            send({1'b0, (ii[6] ? 8'd128 : 8'd127), ii[5:0], low});
            if (i % 10 == 9) idle(1);
        end
        idle(4);
        check("R1 all results returned", 32'(sb.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule